// File: doc/BRIEF.md
# Bus-Master DMA Channel Register File

This block is the software-visible register set of one bus-master DMA channel for a disk controller. It holds a command byte, a status byte and a 32-bit descriptor-table base pointer, all reached through a byte-addressed register port. The port accepts 1-, 2- and 4-byte accesses. Host software programs the table base, then sets the start bit. The block then reloads the current-descriptor pointer of a separate descriptor-walking engine and issues a start pulse to that engine.

Clearing the start bit does not cut a transfer short. The block waits until the engine reports it is idle, and only then drops the active flag and issues a stop pulse. The drive's interrupt request passes straight through to the host. A rising edge of that request also latches the interrupt flag in status, which software clears by writing 1 to it.

Top module: `dmaChanRegs`

## Requirements
- R1: The command register (select 0) stores only bit 0 (start) and bit 3 (direction) of a write. A command read returns those two bits with every other bit zero.
- R2: A command write whose start bit equals the stored start bit changes only the stored bits. It produces no start or stop pulse, no pointer load and no change of the active flag.
- R3: A 0-to-1 change of the start bit has these effects one cycle after the write edge:
  - `curPtrLoad` pulses for one cycle.
  - `curPtr` equals the table base.
  - If the channel was idle, the active flag (status bit 0) becomes 1 and `engStart` pulses for one cycle.
- R4: After a 1-to-0 change of the start bit, the active flag stays 1 while `engBusy` is high. On the first clock edge after the write at which `engBusy` is low, the active flag clears and `engStop` pulses for one cycle.
- R5: A write to the table pointer (select 2) at byte offset N with size code S changes only the addressed bytes. Size codes are 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes, and byte N+k takes write-data byte k. Pointer bits 1:0 always read as zero.
- R6: A table-pointer read at offset N with size code S returns the pointer shifted right by 8·N bits, masked to the access width.
- R7: `hostIrq` follows `driveIrq` at all times. A rising edge of `driveIrq` sets status bit 2 on the next clock edge. A falling edge leaves status unchanged.
- R8: Reset clears the command, status, table pointer and current pointer, cancels any active or pending transfer, and holds all pulses low.
- R9: On a status write (select 1), a 1 in bit 2 clears the interrupt flag and a 1 in bit 1 clears the error flag. Bit 0 (active) ignores the write. Bits 5 and 6 are stored as written. `errSet` sets bit 1. A set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regSel | input | 2 | 0 command, 1 status, 2 table pointer |
| regOfs | input | 2 | Byte offset of the access |
| regSize | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| regWdata | input | 32 | Write data, lane 0 in bits 7:0 |
| regRdata | output | 32 | Read data for the current select, offset and size |
| engBusy | input | 1 | Engine has a transfer in flight |
| errSet | input | 1 | Engine reports an error |
| driveIrq | input | 1 | Interrupt request from the drive |
| engStart | output | 1 | One-cycle start pulse to the engine |
| engStop | output | 1 | One-cycle stop pulse to the engine |
| curPtrLoad | output | 1 | One-cycle pulse: `curPtr` was reloaded |
| curPtr | output | 32 | Engine's current descriptor pointer |
| hostIrq | output | 1 | Interrupt to the host |

## Verification
Most internal faults in this block show up at the ports within one or two cycles. A wrong stored start bit either fires a spurious start or stop pulse on the next same-value command write, or misses a required one. A stuck pending-stop state leaves the active bit set in a status read after the engine goes idle. A wrong lane enable in the pointer datapath shows up on the next full-width pointer read or in `curPtr` after the next start. The sweeps compare every offset and size combination against a byte-lane model computed in the bench.

// File: rtl/dmaRegPkg.sv
package dmaRegPkg;
  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_PTR  = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ptrWr;
    logic loadCur;
  } dpStrobe_t;

  localparam int CMD_START = 0;
  localparam int CMD_DIR   = 3;
  localparam int ST_ACTIVE = 0;
  localparam int ST_ERR    = 1;
  localparam int ST_IRQ    = 2;
  localparam int ST_FLAG0  = 5;
  localparam int ST_FLAG1  = 6;
endpackage

// File: rtl/dmaCtrl.sv
module dmaCtrl
  import dmaRegPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic [1:0]         regSel,
  input  logic [7:0]         wByte,
  input  logic               engBusy,
  input  logic               errSet,
  input  logic               driveIrq,
  output dpStrobe_t          strobe,
  output logic [7:0]         cmdByte,
  output logic [7:0]         statByte,
  output logic               activeQ,
  output logic               engStart,
  output logic               engStop,
  output logic               curLoadPulse
);
  logic startQ, dirQ, stopPending, irqQ, errQ, flagA, flagB, driveIrqQ;
  logic cmdWr, statWr, startUp, startDown, irqRise;

  always_comb begin
    cmdWr     = regWr && (regSel_e'(regSel) == SEL_CMD);
    statWr    = regWr && (regSel_e'(regSel) == SEL_STAT);
    startUp   = cmdWr && wByte[CMD_START] && !startQ;
    startDown = cmdWr && !wByte[CMD_START] && startQ;
    irqRise   = driveIrq && !driveIrqQ;
    strobe.ptrWr   = regWr && (regSel_e'(regSel) == SEL_PTR);
    strobe.loadCur = startUp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= 1'b0; dirQ <= 1'b0; stopPending <= 1'b0; activeQ <= 1'b0;
      engStart <= 1'b0; engStop <= 1'b0; curLoadPulse <= 1'b0;
      irqQ <= 1'b0; errQ <= 1'b0; flagA <= 1'b0; flagB <= 1'b0;
      driveIrqQ <= 1'b0;
    end else begin
      engStart     <= 1'b0;
      engStop      <= 1'b0;
      curLoadPulse <= 1'b0;
      driveIrqQ    <= driveIrq;
      if (cmdWr) begin
        startQ <= wByte[CMD_START];
        dirQ   <= wByte[CMD_DIR];
      end
      if (startUp) begin
        curLoadPulse <= 1'b1;
        stopPending  <= 1'b0;
        if (!activeQ) begin
          activeQ  <= 1'b1;
          engStart <= 1'b1;
        end
      end else if (startDown) begin
        stopPending <= 1'b1;
      end else if (stopPending && !engBusy) begin
        stopPending <= 1'b0;
        activeQ     <= 1'b0;
        engStop     <= 1'b1;
      end
      if (irqRise) irqQ <= 1'b1;
      else if (statWr && wByte[ST_IRQ]) irqQ <= 1'b0;
      if (errSet) errQ <= 1'b1;
      else if (statWr && wByte[ST_ERR]) errQ <= 1'b0;
      if (statWr) begin
        flagA <= wByte[ST_FLAG0];
        flagB <= wByte[ST_FLAG1];
      end
    end
  end

  always_comb begin
    cmdByte = '0;
    cmdByte[CMD_START] = startQ;
    cmdByte[CMD_DIR]   = dirQ;
    statByte = '0;
    statByte[ST_ACTIVE] = activeQ;
    statByte[ST_ERR]    = errQ;
    statByte[ST_IRQ]    = irqQ;
    statByte[ST_FLAG0]  = flagA;
    statByte[ST_FLAG1]  = flagB;
  end
endmodule

// File: rtl/dmaData.sv
module dmaData
  import dmaRegPkg::*;
#(
  parameter int PTR_W = 32,
  localparam int NBYTES = PTR_W / 8,
  localparam int OFS_W = $clog2(NBYTES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [1:0]         regSel,
  input  logic [OFS_W-1:0]   regOfs,
  input  logic [1:0]         regSize,
  input  logic [PTR_W-1:0]   regWdata,
  input  logic [7:0]         cmdByte,
  input  logic [7:0]         statByte,
  output logic [PTR_W-1:0]   regRdata,
  output logic [PTR_W-1:0]   curPtr
);
  logic [PTR_W-1:0] basePtr, laneMask, readMask, wShift, rShift;
  int accBytes;

  always_comb begin
    case (regSize)
      2'd0:    accBytes = 1;
      2'd1:    accBytes = 2;
      default: accBytes = NBYTES;
    endcase
  end

  for (genvar b = 0; b < NBYTES; b++) begin : gLane
    assign laneMask[b*8 +: 8] = {8{(b >= int'(regOfs)) && (b < int'(regOfs) + accBytes)}};
    assign readMask[b*8 +: 8] = {8{b < accBytes}};
  end

  assign wShift = regWdata << {regOfs, 3'b000};
  assign rShift = basePtr >> {regOfs, 3'b000};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      basePtr <= '0;
      curPtr  <= '0;
    end else begin
      if (strobe.ptrWr)
        basePtr <= ((basePtr & ~laneMask) | (wShift & laneMask)) & ~PTR_W'(3);
      if (strobe.loadCur)
        curPtr <= basePtr;
    end
  end

  always_comb begin
    case (regSel_e'(regSel))
      SEL_CMD:  regRdata = PTR_W'(cmdByte);
      SEL_STAT: regRdata = PTR_W'(statByte);
      SEL_PTR:  regRdata = rShift & readMask;
      default:  regRdata = '0;
    endcase
  end
endmodule

// File: rtl/dmaChanRegs.sv
module dmaChanRegs
  import dmaRegPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [1:0]  regSel,
  input  logic [1:0]  regOfs,
  input  logic [1:0]  regSize,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        engBusy,
  input  logic        errSet,
  input  logic        driveIrq,
  output logic        engStart,
  output logic        engStop,
  output logic        curPtrLoad,
  output logic [31:0] curPtr,
  output logic        hostIrq
);
  dpStrobe_t strobe;
  logic [7:0] cmdByte, statByte;
  logic activeQ;

  dmaCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel),
    .wByte(regWdata[7:0]), .engBusy(engBusy), .errSet(errSet),
    .driveIrq(driveIrq), .strobe(strobe), .cmdByte(cmdByte),
    .statByte(statByte), .activeQ(activeQ), .engStart(engStart),
    .engStop(engStop), .curLoadPulse(curPtrLoad)
  );

  dmaData #(.PTR_W(32)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regSel(regSel),
    .regOfs(regOfs), .regSize(regSize), .regWdata(regWdata),
    .cmdByte(cmdByte), .statByte(statByte), .regRdata(regRdata),
    .curPtr(curPtr)
  );

  assign hostIrq = driveIrq;
endmodule

// File: rtl/dmaChanRegsChk.sv
module dmaChanRegsChk (
  input logic        clk,
  input logic        rstN,
  input logic        engBusy,
  input logic        driveIrq,
  input logic        engStart,
  input logic        engStop,
  input logic        curPtrLoad,
  input logic [31:0] curPtr,
  input logic        activeQ,
  input logic [7:0]  cmdByte,
  input logic [7:0]  statByte
);
  AST_CMD_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (cmdByte & 8'hF6) == 8'h00); // R1
  AST_START_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> curPtrLoad); // R3
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> activeQ && !$past(activeQ)); // R3
  AST_STOP_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    engStop |-> !activeQ && !$past(engBusy)); // R4
  AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    curPtr[1:0] == 2'b00); // R5
  AST_IRQ_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveIrq) |=> statByte[2]); // R7
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(engStart && engStop)); // R2
endmodule

bind dmaChanRegs dmaChanRegsChk u_chk (
  .clk(clk), .rstN(rstN), .engBusy(engBusy), .driveIrq(driveIrq),
  .engStart(engStart), .engStop(engStop), .curPtrLoad(curPtrLoad),
  .curPtr(curPtr), .activeQ(activeQ), .cmdByte(cmdByte), .statByte(statByte)
);

// File: tb/test_dmaChanRegs.sv
module test_dmaChanRegs;
  logic clk = 1'b0, rstN = 1'b0, regWr = 1'b0;
  logic [1:0] regSel = 2'd0, regOfs = 2'd0, regSize = 2'd0;
  logic [31:0] regWdata = '0, regRdata, curPtr;
  logic engBusy = 1'b0, errSet = 1'b0, driveIrq = 1'b0;
  logic engStart, engStop, curPtrLoad, hostIrq;
  int nTests = 0, nFail = 0;
  logic [31:0] model;

  always #2 clk = ~clk;

  dmaChanRegs i_dmaChanRegs (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [1:0] o, logic [1:0] z, logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regSel = s; regOfs = o; regSize = z; regWdata = d;
    @(posedge clk);
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(logic [1:0] s, logic [1:0] o, logic [1:0] z, output logic [31:0] d);
    regSel = s; regOfs = o; regSize = z;
    #1 d = regRdata;
  endtask

  function automatic logic [31:0] laneM(int o, int n);
    logic [31:0] m = '0;
    for (int b = 0; b < 4; b++) if (b >= o && b < o + n) m[b*8 +: 8] = 8'hFF;
    return m;
  endfunction

  initial begin
    #400000;
    nFail++; nTests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8 reset state
    rd(2'd0, 0, 2, r); check("R8 cmd", r, 0);
    rd(2'd1, 0, 2, r); check("R8 status", r, 0);
    rd(2'd2, 0, 2, r); check("R8 ptr", r, 0);
    check("R8 outputs", {engStart, engStop, curPtrLoad, hostIrq}, 0);
    check("R8 curPtr", curPtr, 0);

    // R1 command mask sweep
    for (int v = 0; v < 256; v++) begin
      wr(2'd0, 0, 0, 32'(v));
      rd(2'd0, 0, 0, r);
      check("R1 cmd mask", r, 32'(v & 9));
    end
    wr(2'd0, 0, 0, 0);
    repeat (3) @(negedge clk);

    // R5 pointer write sweep, R6 read sweep
    model = '0;
    wr(2'd2, 0, 2, 0);
    for (int z = 0; z < 4; z++) begin
      for (int o = 0; o < 4; o++) begin
        int n;
        logic [31:0] d;
        n = (z == 0) ? 1 : (z == 1) ? 2 : 4;
        if (o + n > 4) continue;
        d = 32'h9E3779B9 * 32'(z * 4 + o + 1);
        wr(2'd2, 2'(o), 2'(z), d);
        model = ((model & ~laneM(o, n)) | ((d << (8 * o)) & laneM(o, n))) & ~32'd3;
        rd(2'd2, 0, 2, r);
        check("R5 ptr lanes", r, model);
        for (int ro = 0; ro < 4; ro++)
          for (int rz = 0; rz < 3; rz++) begin
            int rn;
            rn = (rz == 0) ? 1 : (rz == 1) ? 2 : 4;
            rd(2'd2, 2'(ro), 2'(rz), r);
            check("R6 ptr read", r, (model >> (8 * ro)) & laneM(0, rn));
          end
      end
    end

    // R3 start
    wr(2'd2, 0, 2, 32'h1234_5677);
    wr(2'd0, 0, 0, 32'h01);
    check("R3 start pulse", {engStart, curPtrLoad}, 2'b11);
    check("R3 curPtr", curPtr, 32'h1234_5674);
    rd(2'd1, 0, 0, r); check("R3 active", r & 1, 1);
    @(negedge clk);
    check("R3 single pulse", {engStart, curPtrLoad}, 0);

    // R2 same start value
    wr(2'd2, 0, 2, 32'hAAAA_0000);
    wr(2'd0, 0, 0, 32'h09);
    check("R2 no pulse", {engStart, engStop, curPtrLoad}, 0);
    check("R2 curPtr kept", curPtr, 32'h1234_5674);
    rd(2'd0, 0, 0, r); check("R2 dir stored", r, 9);

    // R4 stop waits for drain
    engBusy = 1'b1;
    wr(2'd0, 0, 0, 32'h00);
    repeat (4) begin
      @(negedge clk);
      check("R4 no early stop", engStop, 0);
      rd(2'd1, 0, 0, r); check("R4 still active", r & 1, 1);
    end
    engBusy = 1'b0;
    @(negedge clk);
    check("R4 stop pulse", engStop, 1);
    rd(2'd1, 0, 0, r); check("R4 inactive", r & 1, 0);
    @(negedge clk);
    check("R4 single stop", engStop, 0);

    // R7 interrupt
    driveIrq = 1'b1; #1;
    check("R7 pass high", hostIrq, 1);
    @(negedge clk);
    rd(2'd1, 0, 0, r); check("R7 irq set", r, 32'h04);
    driveIrq = 1'b0; #1;
    check("R7 pass low", hostIrq, 0);
    @(negedge clk);
    rd(2'd1, 0, 0, r); check("R7 fall keeps", r, 32'h04);

    // R9 status writes
    wr(2'd0, 0, 0, 32'h01);
    @(negedge clk);
    errSet = 1'b1; @(negedge clk); errSet = 1'b0;
    rd(2'd1, 0, 0, r); check("R9 err set", r, 32'h07);
    wr(2'd1, 0, 0, 32'h67);
    rd(2'd1, 0, 0, r); check("R9 w1c flags", r, 32'h61);
    wr(2'd1, 0, 0, 32'h00);
    rd(2'd1, 0, 0, r); check("R9 flags clear", r, 32'h01);

    // R8 reset while active
    rstN = 1'b0; @(negedge clk); rstN = 1'b1;
    rd(2'd1, 0, 0, r); check("R8 status after reset", r, 0);
    rd(2'd2, 0, 2, r); check("R8 ptr after reset", r, 0);
    check("R8 curPtr after reset", curPtr, 0);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule